// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the target side of a two-wire serial bus (I2C-style) in front of a byte-wide nonvolatile store. The bus lines are sampled with the system clock. The block picks out START and STOP conditions and answers its own device byte. It then accepts a 16-bit word address, sent high byte first, and serves current-address reads, random reads, sequential reads and page writes. It drives SDA only through an open-drain enable.

Written bytes go into a 128-byte page buffer and do not reach the array until the master sends STOP. A self-timed programming interval then copies the marked bytes into the array. During that interval the device byte is not acknowledged, so a master can poll for completion. A write-protect input that is high when STOP arrives discards the buffered bytes. The array depth is a parameter. The word address is always 16 bits, and the array uses its low `MEM_AW` bits.

Top module: `eep_slave`

## Requirements
- R1: After reset, and while no START has been seen, `sda_oe_o` is 0, even if the master clocks bits on the bus.
- R2: The device byte is bits [7:4]=1010, bit [3]=0, bits [2:1]=`dev_sel_i`, bit [0]=read (1) or write (0). It is acknowledged (SDA pulled low in the ninth clock) only when every one of these fields matches. Any other byte is not acknowledged.
- R3: After a write-direction device byte, the next two bytes set the word address, high byte first. A repeated START followed by a read-direction device byte then returns the byte stored at that address.
- R4: Bits travel MSB first. Inputs are sampled on the SCL rising edge. The block changes its SDA enable only while SCL is low.
- R5: Each write data byte is acknowledged. The bytes are buffered and written to the array only after STOP. Page locations that the transfer did not write keep their old contents.
- R6: During a write, the low 7 address bits count up and wrap within the 128-byte page. The page number (address bits [15:7]) never changes.
- R7: If `wp_i` is 1 when the write's STOP arrives, the array is left unchanged and no programming interval starts.
- R8: A committed write makes the device busy for `PROG_CYCLES` clock cycles. While busy, the device byte is not acknowledged. Afterwards it is acknowledged again.
- R9: During reads the 16-bit address increments after every byte, across page boundaries. A master ACK fetches the next byte. A master NACK releases SDA and ends the read, and a later current-address read continues from the incremented address.
- R10: START restarts device-byte reception from any state. STOP returns the block to idle. After a byte that is not acknowledged, the block ignores the bus until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| dev_sel_i | input | 2 | Strapped device select bits |
| wp_i | input | 1 | Write protect, high blocks commits |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions assume a well-formed bus. SDA changes only while SCL is low, except at START and STOP. Each SCL phase lasts longer than the synchronizer delay. `PROG_CYCLES` is at least the page size. Under these conditions the block's SDA enable moves only in the low phase, and a START or STOP never coincides with the block holding SDA low. The bench master changes SDA one quarter period after SCL falls, holds every phase for six system clocks, and leaves `wp_i` steady across each transfer. The stimulus therefore stays inside those assumptions.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_ADRH, ST_ADRL, ST_WR, ST_RD, ST_SKIP
  } eep_state_e;

  typedef struct packed {
    logic rise;
    logic fall;
    logic start;
    logic stop;
  } bus_evt_t;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync
  import eep_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     scl_i,
  input  logic     sda_i,
  output logic     scl_o,
  output logic     sda_o,
  output bus_evt_t evt_o
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
        end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_o;
      sda_p <= sda_o;
    end

  assign scl_o = scl_ff[SYNC_STAGES-1];
  assign sda_o = sda_ff[SYNC_STAGES-1];

  always_comb begin
    evt_o.rise  = scl_o & ~scl_p;
    evt_o.fall  = ~scl_o & scl_p;
    evt_o.start = scl_o & scl_p & sda_p & ~sda_o;
    evt_o.stop  = scl_o & scl_p & ~sda_p & sda_o;
  end
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int MEM_AW = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [MEM_AW-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [MEM_AW-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << MEM_AW;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i)
    if (we_i) mem_q[waddr_i] <= wdata_i;

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/eep_page_prog.sv
module eep_page_prog #(
  parameter int PAGE_AW     = 7,
  parameter int DATA_W      = 8,
  parameter int WADDR_W     = 16,
  parameter int PROG_CYCLES = 1000
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       wr_i,
  input  logic [PAGE_AW-1:0]         widx_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic                       commit_i,
  input  logic [WADDR_W-PAGE_AW-1:0] page_i,
  input  logic                       wp_i,
  output logic                       busy_o,
  output logic                       mem_we_o,
  output logic [WADDR_W-1:0]         mem_addr_o,
  output logic [DATA_W-1:0]          mem_data_o
);
  localparam int PAGE_BYTES = 1 << PAGE_AW;
  localparam int PG_W       = WADDR_W - PAGE_AW;
  localparam int CNT_W      = $clog2(PROG_CYCLES + 1);

  logic [DATA_W-1:0]     buf_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;
  logic                  busy_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [PAGE_AW:0]      idx_q;
  logic [PG_W-1:0]       page_q;

  always_ff @(posedge clk_i)
    if (wr_i) buf_q[widx_i] <= wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      busy_q <= 1'b0;
      mask_q <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      page_q <= '0;
    end else if (busy_q) begin
      // one buffered byte per cycle, then wait out the interval
      if (!idx_q[PAGE_AW]) idx_q <= idx_q + 1'b1;
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        mask_q <= '0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else begin
      if (clr_i) mask_q <= '0;
      if (wr_i) mask_q[widx_i] <= 1'b1;
      if (commit_i) begin
        if ((|mask_q) && !wp_i) begin
          busy_q <= 1'b1;
          cnt_q  <= CNT_W'(PROG_CYCLES - 1);
          idx_q  <= '0;
          page_q <= page_i;
        end else begin
          mask_q <= '0;
        end
      end
    end

  assign busy_o     = busy_q;
  assign mem_we_o   = busy_q && !idx_q[PAGE_AW] && mask_q[idx_q[PAGE_AW-1:0]];
  assign mem_addr_o = {page_q, idx_q[PAGE_AW-1:0]};
  assign mem_data_o = buf_q[idx_q[PAGE_AW-1:0]];

  assert_wp_block_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !$past(wp_i));

  assert_page_flushed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(idx_q[PAGE_AW]));
endmodule

// File: rtl/eep_slave.sv
module eep_slave
  import eep_pkg::*;
#(
  parameter int MEM_AW      = 11,
  parameter int PROG_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] dev_sel_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  localparam int WADDR_W = 16;
  localparam int DATA_W  = 8;
  localparam int PAGE_AW = 7;
  localparam int PG_W    = WADDR_W - PAGE_AW;

  logic       scl_s, sda_s;
  bus_evt_t   evt;
  eep_state_e st_q;
  logic [3:0] cnt_q;
  logic       ack_q, oe_q;
  logic [DATA_W-1:0]  rx_q, tx_q, rd_data;
  logic [WADDR_W-1:0] addr_q;
  logic       busy, dev_match, byte_end;
  logic       wr_stb, clr_stb, commit;
  logic       mem_we;
  logic [WADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0]  mem_wdata;

  eep_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .evt_o(evt)
  );

  assign byte_end  = evt.fall && !ack_q && (cnt_q == 4'd8);
  assign dev_match = (rx_q[7:4] == DEV_TYPE) && !rx_q[3] &&
                     (rx_q[2:1] == dev_sel_i) && !busy;
  assign wr_stb    = (st_q == ST_WR) && byte_end && !evt.start && !evt.stop;
  assign clr_stb   = (st_q == ST_ADRL) && byte_end && !evt.start && !evt.stop;
  assign commit    = evt.stop && (st_q == ST_WR);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      ack_q  <= 1'b0;
      oe_q   <= 1'b0;
      rx_q   <= '0;
      tx_q   <= '0;
      addr_q <= '0;
    end else if (evt.start) begin
      st_q  <= ST_DEV;
      cnt_q <= '0;
      ack_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (evt.stop) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      ack_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_DEV, ST_ADRH, ST_ADRL, ST_WR: begin
          if (!ack_q) begin
            if (evt.rise && cnt_q != 4'd8) begin
              rx_q  <= {rx_q[DATA_W-2:0], sda_s};
              cnt_q <= cnt_q + 1'b1;
            end else if (byte_end) begin
              if (st_q == ST_DEV && !dev_match) begin
                st_q <= ST_SKIP;
              end else begin
                ack_q <= 1'b1;
                oe_q  <= 1'b1;
              end
              if (st_q == ST_ADRH) addr_q[15:8] <= rx_q;
              if (st_q == ST_ADRL) addr_q[7:0]  <= rx_q;
              if (st_q == ST_WR)
                addr_q <= {addr_q[WADDR_W-1:PAGE_AW], addr_q[PAGE_AW-1:0] + 1'b1};
            end
          end else if (evt.fall) begin
            ack_q <= 1'b0;
            cnt_q <= '0;
            oe_q  <= 1'b0;
            if (st_q == ST_DEV) begin
              if (rx_q[0]) begin
                st_q   <= ST_RD;
                tx_q   <= rd_data;
                oe_q   <= ~rd_data[7];
                cnt_q  <= 4'd1;
                addr_q <= addr_q + 1'b1;
              end else begin
                st_q <= ST_ADRH;
              end
            end else if (st_q == ST_ADRH) begin
              st_q <= ST_ADRL;
            end else if (st_q == ST_ADRL) begin
              st_q <= ST_WR;
            end
          end
        end
        ST_RD: begin
          if (!ack_q) begin
            if (evt.fall) begin
              if (cnt_q == 4'd8) begin
                oe_q  <= 1'b0;
                ack_q <= 1'b1;
              end else begin
                tx_q  <= tx_q << 1;
                oe_q  <= ~tx_q[6];
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end else if (evt.rise && sda_s) begin
            st_q <= ST_SKIP;   // master NACK
          end else if (evt.fall) begin
            tx_q   <= rd_data;
            oe_q   <= ~rd_data[7];
            cnt_q  <= 4'd1;
            ack_q  <= 1'b0;
            addr_q <= addr_q + 1'b1;
          end
        end
        default: ;
      endcase
    end

  assign sda_oe_o = oe_q;

  eep_page_prog #(
    .PAGE_AW(PAGE_AW), .DATA_W(DATA_W), .WADDR_W(WADDR_W), .PROG_CYCLES(PROG_CYCLES)
  ) u_prog (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(clr_stb), .wr_i(wr_stb), .widx_i(addr_q[PAGE_AW-1:0]), .wdata_i(rx_q),
    .commit_i(commit), .page_i(addr_q[WADDR_W-1:PAGE_AW]), .wp_i(wp_i),
    .busy_o(busy), .mem_we_o(mem_we), .mem_addr_o(mem_waddr), .mem_data_o(mem_wdata)
  );

  eep_mem #(.MEM_AW(MEM_AW), .DATA_W(DATA_W)) u_mem (
    .clk_i(clk_i), .we_i(mem_we), .waddr_i(mem_waddr[MEM_AW-1:0]),
    .wdata_i(mem_wdata), .raddr_i(addr_q[MEM_AW-1:0]), .rdata_o(rd_data)
  );

  generate
    if (MEM_AW < WADDR_W) begin : g_alias
      logic unused_hi;
      assign unused_hi = ^mem_waddr[WADDR_W-1:MEM_AW];
    end
  endgenerate

  assert_oe_scl_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_s);

  assert_dev_mismatch_nack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_DEV) && byte_end &&
     ((rx_q[7:4] != 4'b1010) || rx_q[3] || (rx_q[2:1] != dev_sel_i))) |=> !sda_oe_o);

  assert_busy_nack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && (st_q == ST_DEV)) |-> !sda_oe_o);

  assert_page_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb |=> (addr_q[WADDR_W-1:PAGE_AW] == $past(addr_q[WADDR_W-1:PAGE_AW])));

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !sda_oe_o);

  logic [PG_W-1:0] unused_pg;
  assign unused_pg = '0;
endmodule

// File: tb/eep_slave_bench.sv
module eep_slave_bench;
  localparam int Q     = 6;
  localparam int PROG  = 1000;
  localparam logic [1:0] SEL = 2'b10;
  localparam logic [7:0] DEVW = {4'b1010, 1'b0, SEL, 1'b0};
  localparam logic [7:0] DEVR = {4'b1010, 1'b0, SEL, 1'b1};
  localparam int NVEC = 6;
  localparam logic [23:0] VEC [NVEC] = '{
    24'h0000_3C, 24'h027F_A5, 24'h0280_5E, 24'h07FF_81, 24'h0455_00, 24'h0123_FF
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  always #5 clk = ~clk;

  eep_slave #(.PROG_CYCLES(PROG)) u_eep_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .dev_sel_i(SEL), .wp_i(wp), .sda_oe_o(sda_oe)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic m_wbit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic m_rbit(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic m_wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) m_wbit(d[i]);
    m_rbit(b);
    ack = ~b;
  endtask

  task automatic m_rbyte(input logic nack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      m_rbit(b);
      d[i] = b;
    end
    m_wbit(nack);
  endtask

  task automatic do_write(input logic [15:0] a, input int n);
    logic ack;
    m_start();
    m_wbyte(DEVW, ack);   chk("R2 write device byte ack", 16'(ack), 16'd1);
    m_wbyte(a[15:8], ack); chk("R3 address high ack", 16'(ack), 16'd1);
    m_wbyte(a[7:0], ack);  chk("R3 address low ack", 16'(ack), 16'd1);
    for (int i = 0; i < n; i++) begin
      m_wbyte(wbuf[i], ack);
      chk("R5 data byte ack", 16'(ack), 16'd1);
    end
    m_stop();
  endtask

  task automatic probe(output logic ack);
    m_start();
    m_wbyte(DEVW, ack);
    m_stop();
  endtask

  task automatic wait_ready();
    logic ack;
    int   polls;
    polls = 0;
    ack   = 1'b0;
    while (!ack && polls < 100) begin
      probe(ack);
      polls++;
    end
    chk("R8 device acknowledges after programming interval", 16'(ack), 16'd1);
  endtask

  task automatic do_read(input logic [15:0] a, input int n);
    logic ack;
    m_start();
    m_wbyte(DEVW, ack);
    m_wbyte(a[15:8], ack);
    m_wbyte(a[7:0], ack);
    m_start();
    m_wbyte(DEVR, ack);
    chk("R3 read device byte ack", 16'(ack), 16'd1);
    for (int i = 0; i < n; i++) m_rbyte(i == n - 1, rbuf[i]);
    m_stop();
  endtask

  initial begin
    logic ack;
    logic b;
    repeat (10) @(negedge clk);
    chk("R1 sda released in reset", 16'(sda_oe), 16'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 sda released after reset", 16'(sda_oe), 16'd0);

    // clock a matching device byte without START: must be ignored
    for (int i = 7; i >= 0; i--) m_wbit(DEVW[i]);
    m_rbit(b);
    chk("R1 no ack without START", 16'(b), 16'd1);
    m_stop();

    // vector table: single-byte write, busy probe, random read back
    for (int v = 0; v < NVEC; v++) begin
      wbuf[0] = VEC[v][7:0];
      do_write(VEC[v][23:8], 1);
      probe(ack);
      chk("R8 no ack while programming", 16'(ack), 16'd0);
      wait_ready();
      do_read(VEC[v][23:8], 1);
      chk("R3 R4 random read data", 16'(rbuf[0]), 16'(VEC[v][7:0]));
    end

    // sequential read across a page boundary
    do_read(16'h027F, 2);
    chk("R9 sequential byte 0", 16'(rbuf[0]), 16'h00A5);
    chk("R9 sequential byte 1 next page", 16'(rbuf[1]), 16'h005E);
    chk("R9 sda released after NACK", 16'(sda_oe), 16'd0);

    // current-address read continues after last read
    do_read(16'h027F, 1);
    m_start();
    m_wbyte(DEVR, ack);
    chk("R9 current read ack", 16'(ack), 16'd1);
    m_rbyte(1'b1, rbuf[0]);
    m_stop();
    chk("R9 current address incremented", 16'(rbuf[0]), 16'h005E);

    // device byte mismatches
    m_start();
    m_wbyte({4'b1010, 1'b0, 2'b01, 1'b0}, ack);
    chk("R2 wrong select bits not acked", 16'(ack), 16'd0);
    m_wbyte(8'h00, ack);
    chk("R10 bus ignored after mismatch", 16'(ack), 16'd0);
    m_stop();
    m_start();
    m_wbyte({4'b1010, 1'b1, SEL, 1'b0}, ack);
    chk("R2 bit3 set not acked", 16'(ack), 16'd0);
    m_stop();
    m_start();
    m_wbyte({4'b1110, 1'b0, SEL, 1'b0}, ack);
    chk("R2 wrong type not acked", 16'(ack), 16'd0);
    // repeated START recovers from skip
    m_start();
    m_wbyte(DEVW, ack);
    chk("R10 START restarts reception", 16'(ack), 16'd1);
    m_stop();

    // partial page write keeps neighbours
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    do_write(16'h0188, 4);
    wait_ready();
    wbuf[0] = 8'h77;
    do_write(16'h0189, 1);
    wait_ready();
    do_read(16'h0188, 4);
    chk("R5 untouched byte before", 16'(rbuf[0]), 16'h0011);
    chk("R5 rewritten byte", 16'(rbuf[1]), 16'h0077);
    chk("R5 untouched byte after", 16'(rbuf[2]), 16'h0033);
    chk("R5 untouched byte last", 16'(rbuf[3]), 16'h0044);

    // page wrap from offset 126
    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3;
    do_write(16'h01FE, 3);
    wait_ready();
    do_read(16'h01FE, 2);
    chk("R6 offset 126", 16'(rbuf[0]), 16'h00C1);
    chk("R6 offset 127", 16'(rbuf[1]), 16'h00C2);
    do_read(16'h0180, 1);
    chk("R6 wrapped to offset 0", 16'(rbuf[0]), 16'h00C3);

    // write protect
    wp = 1'b1;
    wbuf[0] = 8'hEE;
    do_write(16'h0000, 1);
    probe(ack);
    chk("R7 no busy interval under protect", 16'(ack), 16'd1);
    wp = 1'b0;
    do_read(16'h0000, 1);
    chk("R7 array unchanged under protect", 16'(rbuf[0]), 16'h003C);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule